// File: doc/BRIEF.md
# Source-Route to Mesh-Address Header Bridge

This block sits between a network interface and a mesh router that disagree on two things: how a packet names its path, and how a flit is handed over. The network interface addresses packets by a nine-hop source route. It exchanges flits under a send/accept handshake. The router expects an 8-bit Y/X destination address and uses a FIFO-style write/write-ok handshake. Both sides run on the same clock.

Outbound traffic goes from the interface to the router. A head flit's 4-bit destination identifier selects an entry in a 16-entry table, and that entry supplies the Y/X address. Inbound traffic goes from the router to the interface. A head flit's 8-bit source address selects an entry in a 256-entry table, and that entry supplies the 18-bit route back to the sender. Body flits cross unchanged. Each direction holds at most one flit in a skid register, so data and framing pass with one cycle of latency and at one flit per cycle.

Both tables are loaded through plain write ports. An inbound lookup that hits an entry never written returns an all-zero route and sets a sticky error flag.

Top module: `route_addr_bridge`

## Requirements
- R1: After reset, neither `mesh_tx_write` nor `ni_rx_send` is asserted, `ni_tx_accept` and `mesh_rx_wok` are high, `route_miss` is low, and every table entry reads as zero. An outbound head with any identifier therefore receives address 0x00.
- R2: A flit is 34 bits: bit 33 is begin-of-packet, bit 32 is end-of-packet, and bits 31:0 are payload. On an outbound flit with bit 33 set, payload bits 7:0 are replaced by the destination table entry indexed by payload bits 21:18. All other bits, both framing bits included, are kept.
- R3: A flit with bit 33 clear passes through either direction with all 34 bits unchanged.
- R4: On an inbound flit with bit 33 set, payload bits 17:0 are replaced by the source table entry indexed by payload bits 15:8, provided that entry has been written since reset. All other bits are kept.
- R5: An inbound head whose source entry has never been written leaves with bits 17:0 all zero and sets `route_miss`. The flag stays set until reset, and later hits do not clear it.
- R6: Each side's ready signal (`ni_tx_accept`, `mesh_rx_wok`) is high exactly when that direction's register is empty or is handing its flit on in the same cycle. A flit that is offered while ready is low is not taken. A held flit stays stable until the downstream side takes it. No flit is lost, duplicated or reordered.
- R7: A flit accepted at a clock edge appears at the far side's outputs right after that edge. With the downstream side ready every cycle, one flit per cycle passes.
- R8: When a table write and a head lookup of the same entry fall in the same cycle, the head flit receives the entry's previous contents. The new contents apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_dst_we | input | 1 | Write strobe for the destination table |
| cfg_dst_idx | input | 4 | Destination identifier to write |
| cfg_dst_addr | input | 8 | Y/X address (Y in 7:4, X in 3:0) stored at that identifier |
| cfg_src_we | input | 1 | Write strobe for the source table |
| cfg_src_idx | input | 8 | Source address to write |
| cfg_src_route | input | 18 | Nine 2-bit hop codes stored at that address |
| ni_tx_send | input | 1 | Interface offers an outbound flit |
| ni_tx_flit | input | 34 | Outbound flit from the interface |
| ni_tx_accept | output | 1 | Bridge takes the outbound flit this cycle |
| mesh_tx_write | output | 1 | Bridge presents a flit to the router |
| mesh_tx_flit | output | 34 | Translated outbound flit |
| mesh_tx_wok | input | 1 | Router takes the presented flit this cycle |
| mesh_rx_write | input | 1 | Router presents an inbound flit |
| mesh_rx_flit | input | 34 | Inbound flit from the router |
| mesh_rx_wok | output | 1 | Bridge takes the inbound flit this cycle |
| ni_rx_send | output | 1 | Bridge offers a flit to the interface |
| ni_rx_flit | output | 34 | Translated inbound flit |
| ni_rx_accept | input | 1 | Interface takes the offered flit this cycle |
| route_miss | output | 1 | Sticky flag for an inbound lookup of an unwritten entry |

## Verification
Two things can land on the same clock edge here. A table write can hit exactly the entry that an arriving head flit is looking up. Separately, a skid register can hand its flit on in the same edge that refills it. The bench provokes the first by raising the destination table write strobe in the same cycle as a head with the same identifier. It then judges the translated address against the old entry, and the following head against the new one. The second case is provoked by holding write-ok low until a second flit is waiting, then releasing it. The bench checks that the held flit is replaced by exactly the waiting one, with nothing skipped or repeated.

// File: rtl/route_addr_bridge.sv
module route_addr_bridge #(
  parameter int PAY_W   = 32,
  parameter int HOP_W   = 2,
  parameter int HOPS    = 9,
  parameter int ADDR_W  = 8,
  parameter int ID_W    = 4,
  parameter int ID_LSB  = 18,
  parameter int SRC_LSB = 8,
  localparam int FLIT_W  = PAY_W + 2,
  localparam int ROUTE_W = HOP_W * HOPS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_dst_we,
  input  logic [ID_W-1:0]    cfg_dst_idx,
  input  logic [ADDR_W-1:0]  cfg_dst_addr,
  input  logic               cfg_src_we,
  input  logic [ADDR_W-1:0]  cfg_src_idx,
  input  logic [ROUTE_W-1:0] cfg_src_route,
  input  logic               ni_tx_send,
  input  logic [FLIT_W-1:0]  ni_tx_flit,
  output logic               ni_tx_accept,
  output logic               mesh_tx_write,
  output logic [FLIT_W-1:0]  mesh_tx_flit,
  input  logic               mesh_tx_wok,
  input  logic               mesh_rx_write,
  input  logic [FLIT_W-1:0]  mesh_rx_flit,
  output logic               mesh_rx_wok,
  output logic               ni_rx_send,
  output logic [FLIT_W-1:0]  ni_rx_flit,
  input  logic               ni_rx_accept,
  output logic               route_miss
);
  localparam int BOP   = FLIT_W - 1;
  localparam int DST_N = 1 << ID_W;
  localparam int SRC_N = 1 << ADDR_W;

  logic [ADDR_W-1:0]  dst_tab [DST_N];
  logic [ROUTE_W-1:0] src_tab [SRC_N];
  logic [SRC_N-1:0]   src_ok;

  logic               tx_full, rx_full;
  logic [FLIT_W-1:0]  tx_q, rx_q, tx_next, rx_next;
  logic [ADDR_W-1:0]  src_sel;
  logic               rx_hit, tx_take, rx_take;

  assign ni_tx_accept  = !tx_full || mesh_tx_wok;
  assign mesh_rx_wok   = !rx_full || ni_rx_accept;
  assign tx_take       = ni_tx_send && ni_tx_accept;
  assign rx_take       = mesh_rx_write && mesh_rx_wok;
  assign mesh_tx_write = tx_full;
  assign mesh_tx_flit  = tx_q;
  assign ni_rx_send    = rx_full;
  assign ni_rx_flit    = rx_q;
  assign src_sel       = mesh_rx_flit[SRC_LSB +: ADDR_W];
  assign rx_hit        = src_ok[src_sel];

  always_comb begin
    tx_next = ni_tx_flit;
    if (ni_tx_flit[BOP])
      tx_next[ADDR_W-1:0] = dst_tab[ni_tx_flit[ID_LSB +: ID_W]];
  end

  always_comb begin
    rx_next = mesh_rx_flit;
    if (mesh_rx_flit[BOP])
      rx_next[ROUTE_W-1:0] = rx_hit ? src_tab[src_sel] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DST_N; i++) dst_tab[i] <= '0;
    end else if (cfg_dst_we) begin
      dst_tab[cfg_dst_idx] <= cfg_dst_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SRC_N; i++) src_tab[i] <= '0;
      src_ok <= '0;
    end else if (cfg_src_we) begin
      src_tab[cfg_src_idx] <= cfg_src_route;
      src_ok[cfg_src_idx]  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_q    <= '0;
    end else if (tx_take) begin
      tx_full <= 1'b1;
      tx_q    <= tx_next;
    end else if (mesh_tx_wok) begin
      tx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_q    <= '0;
    end else if (rx_take) begin
      rx_full <= 1'b1;
      rx_q    <= rx_next;
    end else if (ni_rx_accept) begin
      rx_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                        route_miss <= 1'b0;
    else if (rx_take && mesh_rx_flit[BOP] && !rx_hit) route_miss <= 1'b1;
  end

  a_r6_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mesh_tx_write && !mesh_tx_wok |=> mesh_tx_write && $stable(mesh_tx_flit));
  a_r6_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ni_rx_send && !ni_rx_accept |=> ni_rx_send && $stable(ni_rx_flit));
  a_r7_tx_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ni_tx_send && ni_tx_accept |=> mesh_tx_write);
  a_r7_rx_lands: assert property (@(posedge clk) disable iff (!rst_n)
    mesh_rx_write && mesh_rx_wok |=> ni_rx_send);
  a_r3_tx_body: assert property (@(posedge clk) disable iff (!rst_n)
    ni_tx_send && ni_tx_accept && !ni_tx_flit[BOP] |=> mesh_tx_flit == $past(ni_tx_flit));
  a_r3_rx_body: assert property (@(posedge clk) disable iff (!rst_n)
    mesh_rx_write && mesh_rx_wok && !mesh_rx_flit[BOP] |=> ni_rx_flit == $past(mesh_rx_flit));
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    route_miss |=> route_miss);
  a_r2_framing: assert property (@(posedge clk) disable iff (!rst_n)
    ni_tx_send && ni_tx_accept |=> mesh_tx_flit[BOP -: 2] == $past(ni_tx_flit[BOP -: 2]));
endmodule

// File: tb/test_route_addr_bridge.sv
module test_route_addr_bridge;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        cfg_dst_we, cfg_src_we;
  logic [3:0]  cfg_dst_idx;
  logic [7:0]  cfg_dst_addr, cfg_src_idx;
  logic [17:0] cfg_src_route;
  logic        ni_tx_send, ni_tx_accept, mesh_tx_write, mesh_tx_wok;
  logic        mesh_rx_write, mesh_rx_wok, ni_rx_send, ni_rx_accept, route_miss;
  logic [33:0] ni_tx_flit, mesh_tx_flit, mesh_rx_flit, ni_rx_flit;

  route_addr_bridge i_route_addr_bridge (
    .clk(clk), .rst_n(rst_n),
    .cfg_dst_we(cfg_dst_we), .cfg_dst_idx(cfg_dst_idx), .cfg_dst_addr(cfg_dst_addr),
    .cfg_src_we(cfg_src_we), .cfg_src_idx(cfg_src_idx), .cfg_src_route(cfg_src_route),
    .ni_tx_send(ni_tx_send), .ni_tx_flit(ni_tx_flit), .ni_tx_accept(ni_tx_accept),
    .mesh_tx_write(mesh_tx_write), .mesh_tx_flit(mesh_tx_flit), .mesh_tx_wok(mesh_tx_wok),
    .mesh_rx_write(mesh_rx_write), .mesh_rx_flit(mesh_rx_flit), .mesh_rx_wok(mesh_rx_wok),
    .ni_rx_send(ni_rx_send), .ni_rx_flit(ni_rx_flit), .ni_rx_accept(ni_rx_accept),
    .route_miss(route_miss));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fdst(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  function automatic logic [17:0] froute(input int a);
    return 18'((a * 1031 + 7) & 32'h3FFFF);
  endfunction

  function automatic logic [31:0] tx_head_pay(input int i);
    return 32'h8C01_2377 | (32'(i) << 18);
  endfunction

  task automatic cfg_dst(input int i, input logic [7:0] v);
    @(negedge clk); cfg_dst_we = 1'b1; cfg_dst_idx = 4'(i); cfg_dst_addr = v;
    @(negedge clk); cfg_dst_we = 1'b0;
  endtask

  task automatic cfg_src(input int a, input logic [17:0] r);
    @(negedge clk); cfg_src_we = 1'b1; cfg_src_idx = 8'(a); cfg_src_route = r;
    @(negedge clk); cfg_src_we = 1'b0;
  endtask

  task automatic push_tx(input logic [33:0] f);
    @(negedge clk); ni_tx_send = 1'b1; ni_tx_flit = f;
    @(negedge clk); ni_tx_send = 1'b0;
  endtask

  task automatic push_rx(input logic [33:0] f);
    @(negedge clk); mesh_rx_write = 1'b1; mesh_rx_flit = f;
    @(negedge clk); mesh_rx_write = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_dst_we = 0; cfg_src_we = 0; cfg_dst_idx = 0; cfg_dst_addr = 0;
    cfg_src_idx = 0; cfg_src_route = 0;
    ni_tx_send = 0; ni_tx_flit = 0; mesh_tx_wok = 1;
    mesh_rx_write = 0; mesh_rx_flit = 0; ni_rx_accept = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 mesh_tx_write", mesh_tx_write, 0);
    chk("R1 ni_rx_send", ni_rx_send, 0);
    chk("R1 ni_tx_accept", ni_tx_accept, 1);
    chk("R1 mesh_rx_wok", mesh_rx_wok, 1);
    chk("R1 route_miss", route_miss, 0);
    push_tx({2'b10, tx_head_pay(5)});
    chk("R1 zero table address", mesh_tx_flit, {2'b10, tx_head_pay(5) & 32'hFFFF_FF00});

    // R2 outbound translation sweep over all identifiers
    for (int i = 0; i < 16; i++) cfg_dst(i, fdst(i));
    for (int i = 0; i < 16; i++) begin
      logic [33:0] f;
      f = {1'b1, 1'(i), tx_head_pay(i)};
      push_tx(f);
      chk("R2 head address", mesh_tx_flit, {f[33:8], fdst(i)});
      chk("R7 flit presented", mesh_tx_write, 1);
    end

    // R3 bodies both directions
    for (int k = 0; k < 32; k++) begin
      logic [33:0] f;
      f = {1'b0, 1'(k), 32'(k * 32'h9E37_79B1)};
      push_tx(f);
      chk("R3 outbound body", mesh_tx_flit, f);
      push_rx(f);
      chk("R3 inbound body", ni_rx_flit, f);
    end

    // R4/R5 inbound sweep; even sources written, odd left empty
    for (int a = 0; a < 256; a += 2) cfg_src(a, froute(a));
    for (int a = 0; a < 256; a++) begin
      logic [31:0] p;
      logic [17:0] r;
      p = 32'hC3A4_005A | (32'(a) << 8);
      r = (a % 2 == 0) ? froute(a) : 18'h0;
      push_rx({1'b1, 1'(a >> 1), p});
      if (a % 2 == 0) chk("R4 inbound route", ni_rx_flit, {1'b1, 1'(a >> 1), p[31:18], r});
      else            chk("R5 miss zero route", ni_rx_flit, {1'b1, 1'(a >> 1), p[31:18], r});
      if (a == 0) chk("R5 no miss on hit", route_miss, 0);
      if (a == 1) chk("R5 miss raised", route_miss, 1);
    end
    chk("R5 miss stays after hits", route_miss, 1);

    // R8 same-cycle write and lookup
    @(negedge clk);
    cfg_dst_we = 1; cfg_dst_idx = 4'd3; cfg_dst_addr = 8'hAA;
    ni_tx_send = 1; ni_tx_flit = {2'b10, tx_head_pay(3)};
    @(negedge clk);
    cfg_dst_we = 0; ni_tx_send = 0;
    chk("R8 old entry used", mesh_tx_flit[7:0], fdst(3));
    push_tx({2'b10, tx_head_pay(3)});
    chk("R8 new entry next", mesh_tx_flit[7:0], 8'hAA);

    // R6 outbound backpressure with load and drain in one edge
    @(negedge clk);
    mesh_tx_wok = 0; ni_tx_send = 1; ni_tx_flit = 34'h0_1111_2222;
    #1 chk("R6 accept when empty", ni_tx_accept, 1);
    @(negedge clk);
    ni_tx_flit = 34'h1_3333_4444;
    #1;
    chk("R6 first flit held", mesh_tx_flit, 34'h0_1111_2222);
    chk("R6 accept low when full", ni_tx_accept, 0);
    @(negedge clk);
    chk("R6 not overwritten", mesh_tx_flit, 34'h0_1111_2222);
    mesh_tx_wok = 1;
    #1 chk("R6 accept while draining", ni_tx_accept, 1);
    @(negedge clk);
    ni_tx_send = 0;
    chk("R6 second flit after swap", mesh_tx_flit, 34'h1_3333_4444);
    chk("R6 still presenting", mesh_tx_write, 1);
    @(negedge clk);
    chk("R6 drained", mesh_tx_write, 0);

    // R6 inbound backpressure
    ni_rx_accept = 0;
    push_rx(34'h0_5555_6666);
    chk("R6 inbound held", ni_rx_flit, 34'h0_5555_6666);
    chk("R6 inbound wok low", mesh_rx_wok, 0);
    push_rx(34'h0_7777_8888);
    chk("R6 inbound refused", ni_rx_flit, 34'h0_5555_6666);
    ni_rx_accept = 1;
    @(negedge clk);
    chk("R6 inbound drained", ni_rx_send, 0);

    // R7 back-to-back one flit per cycle
    @(negedge clk);
    ni_tx_send = 1; ni_tx_flit = 34'h0_AAAA_0001;
    @(negedge clk);
    chk("R7 stream flit 1", mesh_tx_flit, 34'h0_AAAA_0001);
    ni_tx_flit = 34'h0_AAAA_0002;
    @(negedge clk);
    chk("R7 stream flit 2", mesh_tx_flit, 34'h0_AAAA_0002);
    ni_tx_send = 0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule